// File: doc/BRIEF.md
# Reset/Hold Pin Role Controller for a Serial Flash

This block sits behind the one shared pin of a low-voltage serial flash that can act either as an active-low hardware reset or as an active-low hold. After power-on the pin is a reset pin. A decoded "enable hold" command strobe from the command decoder moves it into the hold role, where it stays until the next power-on reset. In the reset role the block filters the synchronized pin level against a minimum low width. When a reset qualifies it emits a one-cycle strobe that tells the status register to reload its default, aborts any program or erase the array controller reports as busy, and forces auto-increment programming to exit. It then refuses commands for a recovery window after the pin is released. The window is short after an idle or read state, longer after an interrupted program and longest after an interrupted erase.

The serial output is only allowed to drive while the synchronized pin is high and no reset is being held. In the hold role a low pin raises a pause flag and blocks the output, but it never starts a reset. All time limits are given in picoseconds and converted to clock cycles by rounding up against the clock period parameter.

The sequencer has five states. ST_RUN is normal operation. It goes to ST_QUAL when, in the reset role, the synchronized pin is low. ST_QUAL counts low samples. It returns to ST_RUN if the pin goes high early, and it goes to ST_FIRE on the low sample numbered RST_CYC, where RST_CYC is the minimum low width in cycles. ST_FIRE lasts one cycle and raises the strobes. From there the sequencer goes to ST_RECOVER if the pin is already high, or else to ST_HELD. ST_HELD waits for the pin to rise and then goes to ST_RECOVER. ST_RECOVER counts the recovery window and then goes to ST_RUN. If the pin falls again during the window, it goes back to ST_QUAL.

Top module: `rsthold_pin_ctrl`

## Requirements
- R1: After `por_n` is released, `pin_is_hold` is 0, `cmd_ready` is 1, `hold_pause` is 0, and no strobe output is active.
- R2: An `en_hold_cmd` strobe sampled while `cmd_ready` is 1 sets `pin_is_hold` to 1 on the next clock edge. It stays 1 through any pin activity, and only `por_n` clears it.
- R3: In the reset role, `reset_active` pulses for exactly one cycle after the pin, seen through a two-flop synchronizer, has been low for RST_CYC consecutive samples. A shorter low pulse produces no strobe and leaves `cmd_ready` at 1. `reset_active` is the status-register reload command.
- R4: `so_oe` (1 = output may drive) is 0 whenever the synchronized pin is low, in either role, and from the qualifying edge until the pin is seen high again. It falls two clocks after the pin falls, which is well inside the 107 ns limit.
- R5: During the `reset_active` cycle, `abort_erase` is 1 if `busy_erase` was 1 at the qualifying edge. `abort_prog` is 1 if `busy_prog` was 1 and `busy_erase` was 0, so erase wins when both are 1.
- R6: During the `reset_active` cycle, `aai_exit` is 1 if `aai_mode` was 1 at the qualifying edge.
- R7: `cmd_ready` is 0 from the `reset_active` cycle until the recovery window has elapsed after the synchronized release. The window is REC_R cycles with no activity captured, REC_P cycles if a program or auto-increment mode was captured, and REC_E cycles if an erase was captured.
- R8: In the hold role, `hold_pause` equals the inverted synchronized pin. A low pin never raises `reset_active` or an abort, and `cmd_ready` stays 1.
- R9: An `en_hold_cmd` strobe that arrives while `cmd_ready` is 0 has no effect on `pin_is_hold`.
- R10: Asserting `por_n` returns the pin to the reset role.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| pin_i | input | 1 | Raw level of the shared reset/hold pin |
| en_hold_cmd | input | 1 | One-cycle decoded enable-hold command |
| busy_prog | input | 1 | Array controller is programming |
| busy_erase | input | 1 | Array controller is erasing |
| aai_mode | input | 1 | Auto-address-increment programming mode active |
| pin_is_hold | output | 1 | 1 when the pin has the hold role |
| hold_pause | output | 1 | Hold requested (hold role, pin low) |
| so_oe | output | 1 | Serial output may drive when 1 |
| reset_active | output | 1 | One-cycle qualified reset, status register reload |
| abort_prog | output | 1 | One-cycle program abort |
| abort_erase | output | 1 | One-cycle erase abort |
| aai_exit | output | 1 | One-cycle auto-increment mode exit |
| cmd_ready | output | 1 | Command decoder may accept commands |

## Verification
The bench aims at the pulse-width edge: a low run one sample short of RST_CYC must be ignored, and a run of exactly RST_CYC samples must qualify. A counter that is off by one would either fire on a glitch or miss a minimum-width reset. It measures the recovery length after idle, program, auto-increment and erase captures, and after program and erase together. A wrong priority or a wrong capture would show up as a window of the wrong length or as the wrong abort strobe. It also checks that a hold command sent during recovery is dropped, that a hold-role low pulse far longer than RST_CYC never resets the device, and that only power-on clears the hold role. A design that let pin activity undo the role, or that reset while in the hold role, would fail these checks.

// File: rtl/rsthold_pkg.sv
package rsthold_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_QUAL,
        ST_FIRE,
        ST_HELD,
        ST_RECOVER
    } seq_state_t;

    typedef enum logic [1:0] {
        KIND_IDLE,
        KIND_PROG,
        KIND_ERASE
    } intr_kind_t;

    function automatic int ps_to_cyc(input int t_ps, input int clk_ps);
        return (t_ps + clk_ps - 1) / clk_ps;
    endfunction

endpackage

// File: rtl/rsthold_sync.sv
module rsthold_sync #(
    parameter int STAGES = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d_i};
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/rsthold_role.sv
module rsthold_role (
    input  logic clk,
    input  logic rst_n,
    input  logic en_hold,
    input  logic accept,
    output logic hold_role
);
    logic hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                hold_q <= 1'b0;
        else if (en_hold && accept) hold_q <= 1'b1;
    end

    assign hold_role = hold_q;

    // R2
    role_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |=> hold_q);

    // R9
    role_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_q && !accept) |=> !hold_q);
endmodule

// File: rtl/rsthold_seq.sv
module rsthold_seq
    import rsthold_pkg::*;
#(
    parameter int RST_CYC = 10,
    parameter int REC_R   = 10,
    parameter int REC_P   = 1000,
    parameter int REC_E   = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    input  logic hold_role,
    input  logic busy_prog,
    input  logic busy_erase,
    input  logic aai_mode,
    output logic reset_active,
    output logic abort_prog,
    output logic abort_erase,
    output logic aai_exit,
    output logic cmd_ready,
    output logic so_block
);
    localparam int MAX_A   = (RST_CYC > REC_R) ? RST_CYC : REC_R;
    localparam int MAX_B   = (REC_P > REC_E) ? REC_P : REC_E;
    localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    seq_state_t state, state_n;
    intr_kind_t kind, kind_n;
    logic [CNT_W-1:0] cnt, cnt_n, rec_lim;
    logic cap_prog, cap_prog_n, cap_erase, cap_erase_n, cap_aai, cap_aai_n;

    always_comb begin
        unique case (kind)
            KIND_ERASE: rec_lim = CNT_W'(REC_E);
            KIND_PROG:  rec_lim = CNT_W'(REC_P);
            default:    rec_lim = CNT_W'(REC_R);
        endcase
    end

    always_comb begin
        state_n     = state;
        cnt_n       = cnt;
        kind_n      = kind;
        cap_prog_n  = cap_prog;
        cap_erase_n = cap_erase;
        cap_aai_n   = cap_aai;
        unique case (state)
            ST_RUN: begin
                if (!hold_role && !pin_s) begin
                    state_n = ST_QUAL;
                    cnt_n   = CNT_W'(1);
                end
            end
            ST_QUAL: begin
                if (pin_s) begin
                    state_n = ST_RUN;
                    cnt_n   = '0;
                end else if (cnt == CNT_W'(RST_CYC - 1)) begin
                    state_n     = ST_FIRE;
                    cnt_n       = '0;
                    cap_prog_n  = busy_prog;
                    cap_erase_n = busy_erase;
                    cap_aai_n   = aai_mode;
                    if (busy_erase)                 kind_n = KIND_ERASE;
                    else if (busy_prog || aai_mode) kind_n = KIND_PROG;
                    else                            kind_n = KIND_IDLE;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            ST_FIRE: begin
                cnt_n   = '0;
                state_n = pin_s ? ST_RECOVER : ST_HELD;
            end
            ST_HELD: begin
                if (pin_s) begin
                    state_n = ST_RECOVER;
                    cnt_n   = '0;
                end
            end
            ST_RECOVER: begin
                if (!pin_s) begin
                    state_n = ST_QUAL;
                    cnt_n   = CNT_W'(1);
                end else if (cnt == rec_lim - 1'b1) begin
                    state_n = ST_RUN;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            default: begin
                state_n = ST_RUN;
                cnt_n   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_RUN;
            cnt       <= '0;
            kind      <= KIND_IDLE;
            cap_prog  <= 1'b0;
            cap_erase <= 1'b0;
            cap_aai   <= 1'b0;
        end else begin
            state     <= state_n;
            cnt       <= cnt_n;
            kind      <= kind_n;
            cap_prog  <= cap_prog_n;
            cap_erase <= cap_erase_n;
            cap_aai   <= cap_aai_n;
        end
    end

    always_comb begin
        reset_active = (state == ST_FIRE);
        abort_erase  = (state == ST_FIRE) && cap_erase;
        abort_prog   = (state == ST_FIRE) && cap_prog && !cap_erase;
        aai_exit     = (state == ST_FIRE) && cap_aai;
        cmd_ready    = (state == ST_RUN) || (state == ST_QUAL);
        so_block     = (state == ST_FIRE) || (state == ST_HELD);
    end

    // Independent run-length counter of low samples, used by the checks only.
    logic [CNT_W-1:0] low_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          low_run <= '0;
        else if (pin_s)                      low_run <= '0;
        else if (low_run != CNT_W'(RST_CYC)) low_run <= low_run + 1'b1;
    end

    // R3
    min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_active |-> (low_run == CNT_W'(RST_CYC)));

    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_active |=> !reset_active);

    // R5
    erase_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_erase |-> (reset_active && !abort_prog));

    // R7
    refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_active |=> !cmd_ready);

    // R8
    hold_no_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_role && $past(hold_role)) |-> !reset_active);
endmodule

// File: rtl/rsthold_pin_ctrl.sv
module rsthold_pin_ctrl
    import rsthold_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 10000,
    parameter int RST_MIN_PS    = 100000,
    parameter int HIZ_MAX_PS    = 107000,
    parameter int REC_READ_PS   = 100000,
    parameter int REC_PROG_PS   = 10000000,
    parameter int REC_ERASE_PS  = 1000000000
) (
    input  logic clk,
    input  logic por_n,
    input  logic pin_i,
    input  logic en_hold_cmd,
    input  logic busy_prog,
    input  logic busy_erase,
    input  logic aai_mode,
    output logic pin_is_hold,
    output logic hold_pause,
    output logic so_oe,
    output logic reset_active,
    output logic abort_prog,
    output logic abort_erase,
    output logic aai_exit,
    output logic cmd_ready
);
    localparam int RST_CYC = ps_to_cyc(RST_MIN_PS, CLK_PERIOD_PS);
    localparam int HIZ_CYC = ps_to_cyc(HIZ_MAX_PS, CLK_PERIOD_PS);
    localparam int REC_R   = ps_to_cyc(REC_READ_PS, CLK_PERIOD_PS);
    localparam int REC_P   = ps_to_cyc(REC_PROG_PS, CLK_PERIOD_PS);
    localparam int REC_E   = ps_to_cyc(REC_ERASE_PS, CLK_PERIOD_PS);
    localparam int HIZ_W   = $clog2(HIZ_CYC + 1);

    logic pin_s, hold_role, so_block;

    rsthold_sync #(.STAGES(2), .RST_VAL(1'b1)) sync_i (
        .clk   (clk),
        .rst_n (por_n),
        .d_i   (pin_i),
        .q_o   (pin_s)
    );

    rsthold_role role_i (
        .clk       (clk),
        .rst_n     (por_n),
        .en_hold   (en_hold_cmd),
        .accept    (cmd_ready),
        .hold_role (hold_role)
    );

    rsthold_seq #(
        .RST_CYC (RST_CYC),
        .REC_R   (REC_R),
        .REC_P   (REC_P),
        .REC_E   (REC_E)
    ) seq_i (
        .clk          (clk),
        .rst_n        (por_n),
        .pin_s        (pin_s),
        .hold_role    (hold_role),
        .busy_prog    (busy_prog),
        .busy_erase   (busy_erase),
        .aai_mode     (aai_mode),
        .reset_active (reset_active),
        .abort_prog   (abort_prog),
        .abort_erase  (abort_erase),
        .aai_exit     (aai_exit),
        .cmd_ready    (cmd_ready),
        .so_block     (so_block)
    );

    assign pin_is_hold = hold_role;
    assign hold_pause  = hold_role && !pin_s;
    assign so_oe       = pin_s && !so_block;

    // Raw-pin low counter for the high-impedance deadline check.
    logic [HIZ_W-1:0] raw_low;
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                         raw_low <= '0;
        else if (pin_i)                     raw_low <= '0;
        else if (raw_low != HIZ_W'(HIZ_CYC)) raw_low <= raw_low + 1'b1;
    end

    // R4
    hiz_deadline_chk: assert property (@(posedge clk) disable iff (!por_n)
        (raw_low == HIZ_W'(HIZ_CYC)) |-> !so_oe);

    // R4
    hiz_sync_low_chk: assert property (@(posedge clk) disable iff (!por_n)
        !pin_s |-> !so_oe);

    // R8
    pause_role_chk: assert property (@(posedge clk) disable iff (!por_n)
        hold_pause |-> (pin_is_hold && cmd_ready));
endmodule

// File: tb/rsthold_pin_ctrl_tb_top.sv
module rsthold_pin_ctrl_tb_top;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic por_n, pin_i, en_hold_cmd, busy_prog, busy_erase, aai_mode;
    logic pin_is_hold, hold_pause, so_oe, reset_active;
    logic abort_prog, abort_erase, aai_exit, cmd_ready;

    // 5 ns clock: min width 10, recovery 10 / 40 / 100 cycles.
    rsthold_pin_ctrl #(
        .CLK_PERIOD_PS (5000),
        .RST_MIN_PS    (50000),
        .HIZ_MAX_PS    (53500),
        .REC_READ_PS   (50000),
        .REC_PROG_PS   (200000),
        .REC_ERASE_PS  (500000)
    ) dut_i (
        .clk          (clk),
        .por_n        (por_n),
        .pin_i        (pin_i),
        .en_hold_cmd  (en_hold_cmd),
        .busy_prog    (busy_prog),
        .busy_erase   (busy_erase),
        .aai_mode     (aai_mode),
        .pin_is_hold  (pin_is_hold),
        .hold_pause   (hold_pause),
        .so_oe        (so_oe),
        .reset_active (reset_active),
        .abort_prog   (abort_prog),
        .abort_erase  (abort_erase),
        .aai_exit     (aai_exit),
        .cmd_ready    (cmd_ready)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Output monitors
    bit mon_en = 1'b0;
    int n_rst, n_ap, n_ae, n_aai, n_notready, n_hiz, n_pause, last_low;
    int tick;
    always @(negedge clk) begin
        tick++;
        if (mon_en) begin
            if (reset_active) n_rst++;
            if (abort_prog)   n_ap++;
            if (abort_erase)  n_ae++;
            if (aai_exit)     n_aai++;
            if (!cmd_ready)   n_notready++;
            if (!so_oe)       n_hiz++;
            if (hold_pause)   n_pause++;
        end
    end

    task automatic clear_mon();
        n_rst = 0; n_ap = 0; n_ae = 0; n_aai = 0;
        n_notready = 0; n_hiz = 0; n_pause = 0; last_low = 0;
    endtask

    typedef struct packed {
        int unsigned len;
        logic bp, be, aai;
        logic e_rst, e_ap, e_ae, e_aai;
        int unsigned e_last;
    } vec_t;

    // last negedge (counted from release) with cmd_ready low: 2 + window
    localparam vec_t VEC [8] = '{
        '{len: 3,  bp: 0, be: 0, aai: 0, e_rst: 0, e_ap: 0, e_ae: 0, e_aai: 0, e_last: 0},
        '{len: 9,  bp: 0, be: 0, aai: 0, e_rst: 0, e_ap: 0, e_ae: 0, e_aai: 0, e_last: 0},
        '{len: 10, bp: 0, be: 0, aai: 0, e_rst: 1, e_ap: 0, e_ae: 0, e_aai: 0, e_last: 12},
        '{len: 25, bp: 1, be: 0, aai: 0, e_rst: 1, e_ap: 1, e_ae: 0, e_aai: 0, e_last: 42},
        '{len: 12, bp: 0, be: 1, aai: 0, e_rst: 1, e_ap: 0, e_ae: 1, e_aai: 0, e_last: 102},
        '{len: 12, bp: 1, be: 1, aai: 0, e_rst: 1, e_ap: 0, e_ae: 1, e_aai: 0, e_last: 102},
        '{len: 15, bp: 0, be: 0, aai: 1, e_rst: 1, e_ap: 0, e_ae: 0, e_aai: 1, e_last: 42},
        '{len: 9,  bp: 0, be: 1, aai: 0, e_rst: 0, e_ap: 0, e_ae: 0, e_aai: 0, e_last: 0}
    };

    // Drive a low pulse of len negedges, then watch 160 negedges after release.
    task automatic pulse(input int len, input logic bp, input logic be, input logic am);
        clear_mon();
        @(negedge clk);
        mon_en     = 1'b1;
        busy_prog  = bp;
        busy_erase = be;
        aai_mode   = am;
        pin_i      = 1'b0;
        repeat (len) @(negedge clk);
        pin_i = 1'b1;
        for (int k = 1; k <= 160; k++) begin
            @(negedge clk);
            if (!cmd_ready) last_low = k;
            if (k == 5) begin
                busy_prog = 1'b0; busy_erase = 1'b0; aai_mode = 1'b0;
            end
        end
        mon_en = 1'b0;
    endtask

    initial begin
        por_n = 1'b0; pin_i = 1'b1; en_hold_cmd = 1'b0;
        busy_prog = 1'b0; busy_erase = 1'b0; aai_mode = 1'b0;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state
        check("R1 pin_is_hold", pin_is_hold, 0);
        check("R1 cmd_ready", cmd_ready, 1);
        check("R1 hold_pause", hold_pause, 0);
        check("R1 reset_active", reset_active, 0);
        check("R1 so_oe", so_oe, 1);

        // Table: R3 width, R4 high-Z, R5 aborts, R6 aai exit, R7 windows
        for (int i = 0; i < 8; i++) begin
            pulse(VEC[i].len, VEC[i].bp, VEC[i].be, VEC[i].aai);
            check("R3 reset strobes", n_rst, int'(VEC[i].e_rst));
            check("R5 abort_prog", n_ap, int'(VEC[i].e_ap));
            check("R5 abort_erase", n_ae, int'(VEC[i].e_ae));
            check("R6 aai_exit", n_aai, int'(VEC[i].e_aai));
            check("R7 recovery end", last_low, int'(VEC[i].e_last));
            check("R4 output blocked", int'(n_hiz > 0), 1);
            if (VEC[i].e_rst == 1'b0)
                check("R3 short pulse keeps cmd_ready", n_notready, 0);
        end

        // R4: so_oe falls two clocks after the pin falls
        @(negedge clk);
        pin_i = 1'b0;
        @(negedge clk);
        check("R4 so_oe before sync", so_oe, 1);
        @(negedge clk);
        check("R4 so_oe after sync", so_oe, 0);
        pin_i = 1'b1;
        repeat (20) @(negedge clk);

        // R9: hold command during erase recovery is dropped
        @(negedge clk);
        busy_erase = 1'b1;
        pin_i = 1'b0;
        repeat (12) @(negedge clk);
        pin_i = 1'b1;
        busy_erase = 1'b0;
        repeat (10) @(negedge clk);
        check("R9 in recovery", cmd_ready, 0);
        en_hold_cmd = 1'b1;
        @(negedge clk);
        en_hold_cmd = 1'b0;
        repeat (120) @(negedge clk);
        check("R9 role unchanged", pin_is_hold, 0);
        check("R9 ready again", cmd_ready, 1);

        // R2: accepted hold command
        en_hold_cmd = 1'b1;
        @(negedge clk);
        en_hold_cmd = 1'b0;
        check("R2 role set", pin_is_hold, 1);

        // R8: long low in hold role
        clear_mon();
        mon_en = 1'b1;
        pin_i = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 hold_pause", hold_pause, 1);
        check("R8 so_oe", so_oe, 0);
        repeat (30) @(negedge clk);
        pin_i = 1'b1;
        repeat (3) @(negedge clk);
        mon_en = 1'b0;
        check("R8 pause released", hold_pause, 0);
        check("R8 no reset", n_rst, 0);
        check("R8 no abort", n_ap + n_ae + n_aai, 0);
        check("R8 cmd_ready kept", n_notready, 0);
        check("R2 role sticky", pin_is_hold, 1);

        // R10: power-on returns reset role
        por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 role cleared", pin_is_hold, 0);
        pulse(12, 1'b0, 1'b0, 1'b0);
        check("R10 reset role works", n_rst, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule